// File: doc/BRIEF.md
# Banked Read Arbiter for Parallel Scan Engines

Several scan engines walk state machines that are stored across a set of equal-size memory banks. Each engine names the state it needs next by a state identifier. The top bits of that identifier pick the bank, and the remaining bits give the word address inside the bank. An engine keeps at most one read open: it raises a request, holds it until it is granted, and then waits for its data. It issues no new request until that data has come back.

Every bank has two read ports, so each bank accepts up to two requests in a cycle. When more engines want the same bank, a rotating priority per bank decides which two go first. The rest keep their requests raised and are served in later cycles.

The bank memories sit outside the block. A granted read appears on a bank port in the cycle of the grant. The bank returns the word a fixed four cycles later on the same port. A short tag pipeline remembers which engine used each port, so the word is handed back to that engine.

Top module: `bank_read_arbiter`

## Requirements
- R1: A request with identifier `id` goes to bank `id[7:6]`, and the port address is `id[5:0]` (default 8-bit identifier, four banks).
- R2: Each bank enables at most two ports per cycle. Port 1 is used only when port 0 is also used, and the two ports never carry the same engine.
- R3: A request that finds both ports of its bank taken is not granted in that cycle. It stays raised and is granted in a later cycle.
- R4: If a bank sees one or two requests in a cycle, every one of them is granted in that same cycle.
- R5: Each bank has a pointer that is 0 after reset. Requesters are scanned from the pointer upward, wrapping around: the first one found gets port 0 and the second gets port 1. After any grant, the pointer moves to one past the last engine granted in that bank.
- R6: The word a bank port returns four cycles after a grant appears on `rsp_data` of the granted engine, with `rsp_valid` high for exactly that one cycle.
- R7: While reset is asserted, no grant, no bank port enable and no response is produced, even when requests are raised.
- R8: A raised request is refused in at most (N_ENG-1)/2 cycles before it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_ENG | Per-engine read request, held until granted |
| req_id | input | N_ENG x ID_W | Per-engine state identifier (bank field on top) |
| req_gnt | output | N_ENG | Per-engine grant, same cycle as the request |
| rsp_valid | output | N_ENG | Per-engine read data valid |
| rsp_data | output | N_ENG x DATA_W | Per-engine read data |
| bank_rd_en | output | N_BANK x 2 | Read enable per bank port |
| bank_rd_addr | output | N_BANK x 2 x ADDR_W | Word address per bank port |
| bank_rd_data | input | N_BANK x 2 x DATA_W | Word returned per bank port, four cycles after its enable |

## Verification
The critical overlap is a cycle in which an engine's response is steered back while other engines are being arbitrated for the same bank. In that cycle the returning word and the new grants share bank ports and the engine index space. The bench keeps all four engines busy with short or zero gaps. This makes a response for one engine coincide with grants for the others, and it also packs all requests into a single bank so that three or four of them compete. A behavioural model with its own rotating pointers and per-engine due cycles predicts each grant, port address and response word. These predictions are compared with the ports every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned BANK_PORTS = 2;
    localparam int unsigned TAG_ENG_W  = 8;

    typedef struct packed {
        logic                 vld;
        logic [TAG_ENG_W-1:0] eng;
    } tag_t;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/rr_pick2.sv
module rr_pick2 #(
    parameter int unsigned N_REQ = 4,
    localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_REQ-1:0]          req,
    output logic [1:0]                gnt_vld,
    output logic [1:0][IDX_W-1:0]     gnt_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        int pos;
        nxt_d   = cur_q;
        gnt_vld = '0;
        gnt_idx = '0;
        for (int k = 0; k < int'(N_REQ); k++) begin
            pos = (int'(cur_q.ptr) + k) % int'(N_REQ);
            if (req[pos]) begin
                if (!gnt_vld[0]) begin
                    gnt_vld[0] = 1'b1;
                    gnt_idx[0] = IDX_W'(pos);
                end else if (!gnt_vld[1]) begin
                    gnt_vld[1] = 1'b1;
                    gnt_idx[1] = IDX_W'(pos);
                end
            end
        end
        if (gnt_vld[1]) begin
            nxt_d.ptr = IDX_W'(arb_pkg::wrap_inc(32'(gnt_idx[1]), N_REQ));
        end else if (gnt_vld[0]) begin
            nxt_d.ptr = IDX_W'(arb_pkg::wrap_inc(32'(gnt_idx[0]), N_REQ));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2: the two ports of a bank never serve the same engine
    a_r2_distinct_ports: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld[0] && gnt_vld[1]) |-> (gnt_idx[0] != gnt_idx[1]));

    // R3: only raised requests are granted
    a_r3_port0_requested: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld[0] |-> req[gnt_idx[0]]);
    a_r3_port1_requested: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld[1] |-> req[gnt_idx[1]]);

    // R4: no port stays idle while a request for the bank is pending
    a_r4_one_served: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_vld[0]);
    a_r4_two_served: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) >= 2) |-> (gnt_vld[0] && gnt_vld[1]));
endmodule

// File: rtl/tag_pipe.sv
module tag_pipe #(
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  arb_pkg::tag_t tag_in,
    output arb_pkg::tag_t tag_out
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        arb_pkg::tag_t [DEPTH-1:0] stg;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.stg[0] = tag_in;
        for (int k = 1; k < int'(DEPTH); k++) begin
            nxt_d.stg[k] = cur_q.stg[k-1];
        end
    end

    assign tag_out = cur_q.stg[DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/bank_read_arbiter.sv
module bank_read_arbiter #(
    parameter int unsigned N_ENG  = 4,
    parameter int unsigned N_BANK = 4,
    parameter int unsigned ID_W   = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LAT    = 4,
    localparam int unsigned BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int unsigned ADDR_W = ID_W - BANK_W,
    localparam int unsigned NP     = arb_pkg::BANK_PORTS
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N_ENG-1:0]                        req_valid,
    input  logic [N_ENG-1:0][ID_W-1:0]              req_id,
    output logic [N_ENG-1:0]                        req_gnt,
    output logic [N_ENG-1:0]                        rsp_valid,
    output logic [N_ENG-1:0][DATA_W-1:0]            rsp_data,
    output logic [N_BANK-1:0][NP-1:0]               bank_rd_en,
    output logic [N_BANK-1:0][NP-1:0][ADDR_W-1:0]   bank_rd_addr,
    input  logic [N_BANK-1:0][NP-1:0][DATA_W-1:0]   bank_rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned ENG_W  = (N_ENG > 1) ? $clog2(N_ENG) : 1;
    localparam int unsigned WAIT_W = $clog2(N_ENG + 2) + 1;

    logic [N_BANK-1:0][N_ENG-1:0]           bank_req;
    logic [N_BANK-1:0][NP-1:0]              pick_vld;
    logic [N_BANK-1:0][NP-1:0][ENG_W-1:0]   pick_idx;
    arb_pkg::tag_t [N_BANK-1:0][NP-1:0]     tag_in;
    arb_pkg::tag_t [N_BANK-1:0][NP-1:0]     tag_out;
    logic [N_ENG-1:0][N_BANK*NP-1:0]        rsp_hits;

    // request routing by bank field
    always_comb begin
        for (int b = 0; b < int'(N_BANK); b++) begin
            for (int e = 0; e < int'(N_ENG); e++) begin
                bank_req[b][e] = rst_n && req_valid[e] &&
                                 (req_id[e][ID_W-1 -: BANK_W] == BANK_W'(b));
            end
        end
    end

    for (genvar gb = 0; gb < N_BANK; gb++) begin : g_bank
        rr_pick2 #(.N_REQ(N_ENG)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (bank_req[gb]),
            .gnt_vld (pick_vld[gb]),
            .gnt_idx (pick_idx[gb])
        );
        for (genvar gp = 0; gp < NP; gp++) begin : g_port
            tag_pipe #(.DEPTH(LAT)) u_tag (
                .clk     (clk),
                .rst_n   (rst_n),
                .tag_in  (tag_in[gb][gp]),
                .tag_out (tag_out[gb][gp])
            );

            // R1: a port only carries an engine whose bank field names this bank
            a_r1_bank_field: assert property (@(posedge clk) disable iff (!rst_n)
                pick_vld[gb][gp] |->
                (req_id[pick_idx[gb][gp]][ID_W-1 -: BANK_W] == BANK_W'(gb)));
        end
    end

    // grant fan-out, bank port drive, response steering
    always_comb begin
        req_gnt      = '0;
        bank_rd_en   = '0;
        bank_rd_addr = '0;
        rsp_valid    = '0;
        rsp_data     = '0;
        rsp_hits     = '0;
        for (int b = 0; b < int'(N_BANK); b++) begin
            for (int p = 0; p < int'(NP); p++) begin
                tag_in[b][p].vld = pick_vld[b][p];
                tag_in[b][p].eng = arb_pkg::TAG_ENG_W'(pick_idx[b][p]);
                if (pick_vld[b][p]) begin
                    req_gnt[pick_idx[b][p]] = 1'b1;
                    bank_rd_en[b][p]        = 1'b1;
                    bank_rd_addr[b][p]      = req_id[pick_idx[b][p]][ADDR_W-1:0];
                end
                if (tag_out[b][p].vld) begin
                    rsp_valid[tag_out[b][p].eng[ENG_W-1:0]] = 1'b1;
                    rsp_data[tag_out[b][p].eng[ENG_W-1:0]]  = bank_rd_data[b][p];
                end
                for (int e = 0; e < int'(N_ENG); e++) begin
                    rsp_hits[e][b*NP+p] = tag_out[b][p].vld &&
                        (tag_out[b][p].eng == arb_pkg::TAG_ENG_W'(e));
                end
            end
        end
    end

    // wait tracking for the fairness bound
    typedef struct packed {
        logic [N_ENG-1:0][WAIT_W-1:0] wait_cnt;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        for (int e = 0; e < int'(N_ENG); e++) begin
            if (req_valid[e] && !req_gnt[e]) begin
                if (cur_q.wait_cnt[e] != '1) begin
                    nxt_d.wait_cnt[e] = cur_q.wait_cnt[e] + 1'b1;
                end
            end else begin
                nxt_d.wait_cnt[e] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar ge = 0; ge < N_ENG; ge++) begin : g_eng_chk
        // R8: a held request is never refused for long
        a_r8_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
            cur_q.wait_cnt[ge] < WAIT_W'(N_ENG));
        // R6: at most one returning word per engine in a cycle
        a_r6_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rsp_hits[ge]));
    end
endmodule

// File: tb/sim_bank_read_arbiter.sv
module sim_bank_read_arbiter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_ENG  = 4;
    localparam int N_BANK = 4;
    localparam int ID_W   = 8;
    localparam int DATA_W = 16;
    localparam int LAT    = 4;
    localparam int ADDR_W = 6;
    localparam int NCYC   = 1000;

    logic                                  clk = 1'b0;
    logic                                  rst_n;
    logic [N_ENG-1:0]                      req_valid;
    logic [N_ENG-1:0][ID_W-1:0]            req_id;
    logic [N_ENG-1:0]                      req_gnt;
    logic [N_ENG-1:0]                      rsp_valid;
    logic [N_ENG-1:0][DATA_W-1:0]          rsp_data;
    logic [N_BANK-1:0][1:0]                bank_rd_en;
    logic [N_BANK-1:0][1:0][ADDR_W-1:0]    bank_rd_addr;
    logic [N_BANK-1:0][1:0][DATA_W-1:0]    bank_rd_data;

    always #2.5 clk = ~clk;

    bank_read_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_gnt(req_gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bank_rd_en(bank_rd_en), .bank_rd_addr(bank_rd_addr),
        .bank_rd_data(bank_rd_data)
    );

    function automatic logic [DATA_W-1:0] mem_word(int b, int a);
        return DATA_W'((b * 4099) ^ (a * 37) ^ 16'h5A3C);
    endfunction

    // behavioural bank memories with a fixed read delay
    logic [N_BANK-1:0][1:0]             en_p [LAT];
    logic [N_BANK-1:0][1:0][ADDR_W-1:0] ad_p [LAT];

    always @(posedge clk) begin
        en_p[0] <= bank_rd_en;
        ad_p[0] <= bank_rd_addr;
        for (int k = 1; k < LAT; k++) begin
            en_p[k] <= en_p[k-1];
            ad_p[k] <= ad_p[k-1];
        end
    end

    always_comb begin
        for (int b = 0; b < N_BANK; b++) begin
            for (int p = 0; p < 2; p++) begin
                bank_rd_data[b][p] = (en_p[LAT-1][b][p] === 1'b1) ?
                    mem_word(b, int'(ad_p[LAT-1][b][p])) : '0;
            end
        end
    end

    int errs = 0;
    int checks = 0;
    bit done = 0;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // reference state
    int ptr     [N_BANK];
    int st      [N_ENG];   // 0 idle, 1 requesting, 2 waiting for data
    int gap     [N_ENG];
    int waitc   [N_ENG];
    int due     [N_ENG];
    int due_dat [N_ENG];
    bit exp_gnt [N_ENG];
    bit exp_en  [N_BANK][2];
    int exp_ad  [N_BANK][2];

    function automatic logic [ID_W-1:0] new_id(int e, int cyc);
        logic [5:0] a;
        a = 6'($urandom);
        if (cyc < 300) return 8'($urandom);
        if (cyc < 600) return {2'b10, a};
        if (cyc < 800) begin
            if (e < 2)  return {2'b01, a};
            if (e == 2) return {2'b00, a};
            return {2'b11, a};
        end
        return 8'($urandom);
    endfunction

    task automatic model_step(int cyc);
        int cnt;
        int last;
        int eng;
        for (int e = 0; e < N_ENG; e++) exp_gnt[e] = 0;
        for (int b = 0; b < N_BANK; b++) begin
            cnt = 0;
            last = 0;
            exp_en[b][0] = 0;
            exp_en[b][1] = 0;
            for (int k = 0; k < N_ENG; k++) begin
                eng = (ptr[b] + k) % N_ENG;
                if (req_valid[eng] && int'(req_id[eng][7:6]) == b && cnt < 2) begin
                    exp_gnt[eng] = 1;
                    exp_en[b][cnt] = 1;
                    exp_ad[b][cnt] = int'(req_id[eng][5:0]);
                    last = eng;
                    cnt++;
                end
            end
            if (cnt > 0) ptr[b] = (last + 1) % N_ENG;
        end
        // R5 / R3: grant choice per engine
        for (int e = 0; e < N_ENG; e++) begin
            chk((cyc >= 300 && cyc < 600) ? "R3" : "R5", $sformatf("gnt[%0d]", e),
                int'(req_gnt[e]), int'(exp_gnt[e]));
        end
        // R1 / R2: bank port enables and addresses
        for (int b = 0; b < N_BANK; b++) begin
            for (int p = 0; p < 2; p++) begin
                chk("R2", $sformatf("en[%0d][%0d]", b, p),
                    int'(bank_rd_en[b][p]), int'(exp_en[b][p]));
                if (exp_en[b][p])
                    chk("R1", $sformatf("addr[%0d][%0d]", b, p),
                        int'(bank_rd_addr[b][p]), exp_ad[b][p]);
            end
        end
        // R4: light load on each bank is served at once
        if (cyc >= 600 && cyc < 800) begin
            for (int e = 0; e < N_ENG; e++)
                if (req_valid[e]) chk("R4", $sformatf("immediate gnt[%0d]", e), int'(req_gnt[e]), 1);
        end
        // R6: responses
        for (int e = 0; e < N_ENG; e++) begin
            chk("R6", $sformatf("rsp_valid[%0d]", e), int'(rsp_valid[e]), int'(due[e] == cyc));
            if (due[e] == cyc)
                chk("R6", $sformatf("rsp_data[%0d]", e), int'(rsp_data[e]), due_dat[e]);
        end
        // engine bookkeeping
        for (int e = 0; e < N_ENG; e++) begin
            if (st[e] == 1) begin
                if (exp_gnt[e]) begin
                    chk("R8", $sformatf("wait[%0d]", e), int'(waitc[e] <= (N_ENG - 1) / 2), 1);
                    st[e] = 2;
                    due[e] = cyc + LAT;
                    due_dat[e] = int'(mem_word(int'(req_id[e][7:6]), int'(req_id[e][5:0])));
                end else begin
                    waitc[e]++;
                end
            end else if (st[e] == 2 && due[e] == cyc) begin
                st[e] = 0;
                gap[e] = (cyc >= 300 && cyc < 600) ? 0 : int'($urandom % 3);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = '0;
        req_id = '0;
        for (int b = 0; b < N_BANK; b++) ptr[b] = 0;
        for (int e = 0; e < N_ENG; e++) begin
            st[e] = 0; gap[e] = 0; waitc[e] = 0; due[e] = -1; due_dat[e] = 0;
        end
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            if (cyc < 4) begin
                rst_n = 1'b0;
                req_valid = '1;
                for (int e = 0; e < N_ENG; e++) req_id[e] = 8'(e * 3);
            end else begin
                rst_n = 1'b1;
                for (int e = 0; e < N_ENG; e++) begin
                    if (st[e] == 0) begin
                        if (gap[e] == 0) begin
                            st[e] = 1;
                            waitc[e] = 0;
                            req_id[e] = new_id(e, cyc);
                        end else begin
                            gap[e]--;
                        end
                    end
                    req_valid[e] = (st[e] == 1);
                end
            end
            #1;
            if (cyc < 4) begin
                // R7: nothing moves while reset is held
                chk("R7", "req_gnt in reset", int'(req_gnt), 0);
                chk("R7", "bank_rd_en in reset", int'(bank_rd_en), 0);
                chk("R7", "rsp_valid in reset", int'(rsp_valid), 0);
            end else begin
                model_step(cyc);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule